// File: doc/BRIEF.md
# USB Receive Endpoint Control and Status

This block holds the control and status logic for one receive (host-to-device) endpoint of a USB function controller. It sits between a 16-bit CPU register and the endpoint's receive buffer. From the packet engine it takes an end-of-packet event with the packet's data PID, its length and its CRC result. For each event it decides whether the data set is stored, and which handshake goes back to the host: ACK, NAK, STALL or none.

The block counts how many received data sets are waiting, in either single-buffer or double-buffer mode. It reports that count as a mode-specific code. It raises sticky flags for three conditions: overrun, oversize and corrupted data. It keeps the expected DATA0/DATA1 toggle. The CPU acts on the endpoint in two ways. It writes 1 to self-clearing action bits to release data sets or to clear flags. It also writes three configuration bits: isochronous, stall and automatic release.

Top module: `usb_out_ep_ctrl`

## Requirements
- R1: After reset the register reads 0x0000. Bits [1:0] give the occupancy: 00 means empty. In single-buffer mode (dbl_buf_i=0), one stored set reads 10. In double-buffer mode, one set reads 01 and two sets read 11.
- R2: A good packet that arrives while the buffer is full gets NAK (hs_code_o=10) and is not stored. It sets the overrun flag (bit 2), which stays set until a write with bit 6 set.
- R3: A packet longer than MAXP gets STALL (hs_code_o=11) and is not stored. It sets the oversize flag (bit 3). While bit 3 is set, every packet gets STALL and none is stored. A write with bit 7 set clears it. A length equal to MAXP is accepted.
- R4: A packet with a CRC error gets no handshake and is not stored. It sets the data-error flag (bit 4), which a write with bit 8 clears.
- R5: Writing 1 to bit 5 (buffer ready) or to bit 10 (flush) releases one stored set. On an empty buffer, either write has no effect.
- R6: With bit 13 (auto-release) set, a pulse on rd_done_i releases one set. With bit 13 clear, rd_done_i is ignored.
- R7: The expected toggle starts at DATA0 (pkt_pid_i=0). A stored packet flips it. A packet whose PID does not match is ACKed (01) but not stored. Writing 1 to bit 9 sets the expectation back to DATA0, and this wins over a flip in the same cycle.
- R8: While bit 12 (send-stall) is 1, every packet gets STALL and none is stored. Writing 0 to bit 12 resumes normal handling.
- R9: While bit 11 (isochronous) is 1, no handshake is sent and the PID is not checked. Good packets are stored without flipping the toggle.
- R10: Bits 5 to 10 and bits 15:14 always read 0. Configuration bits 11 to 13 read back the last value written. hs_valid_o pulses exactly one cycle after pkt_valid_i. The checks on a packet apply in this order: stall (bit 12 or bit 3), oversize, CRC error, full, toggle.
- R11: When a flag's set event and its CPU clear strobe occur in the same cycle, the flag ends set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| dbl_buf_i | input | 1 | 1 selects double-buffer mode; change only while empty |
| reg_wr_i | input | 1 | CPU register write strobe |
| reg_wdata_i | input | 16 | CPU write data |
| reg_rdata_o | output | 16 | Register read value |
| pkt_valid_i | input | 1 | One-cycle end-of-packet event |
| pkt_pid_i | input | 1 | Data PID of packet: 0 DATA0, 1 DATA1 |
| pkt_len_i | input | LEN_W | Packet length in bytes |
| pkt_crc_err_i | input | 1 | Packet failed its CRC |
| rd_done_i | input | 1 | CPU finished reading one set from the buffer |
| hs_valid_o | output | 1 | Handshake to be sent |
| hs_code_o | output | 2 | 01 ACK, 10 NAK, 11 STALL |

## Verification
The bench fills the buffer in both modes and then sends one more packet. A wrong fullness test would store a third set or would answer ACK when NAK is due. It sends a packet at MAXP and one at MAXP+1, which catches an off-by-one comparison. It lines up a flag set with its clear strobe in the same cycle, and a toggle reset with a packet store in the same cycle. A design with the wrong priority in either case would lose the overrun or accept the next DATA1. It also pulses rd_done_i while auto-release is off and sends a wrong-PID packet on an isochronous endpoint. A design that gated either one wrongly would change the occupancy or send a handshake.

// File: rtl/usb_out_ep_pkg.sv
package usb_out_ep_pkg;
  typedef enum logic [1:0] {
    HS_NONE  = 2'b00,
    HS_ACK   = 2'b01,
    HS_NAK   = 2'b10,
    HS_STALL = 2'b11
  } hs_e;

  localparam int unsigned B_OVR      = 2;
  localparam int unsigned B_BIG      = 3;
  localparam int unsigned B_DERR     = 4;
  localparam int unsigned B_CLR_RDY  = 5;
  localparam int unsigned B_CLR_OVR  = 6;
  localparam int unsigned B_CLR_BIG  = 7;
  localparam int unsigned B_CLR_DERR = 8;
  localparam int unsigned B_TOG_INIT = 9;
  localparam int unsigned B_FLUSH    = 10;
  localparam int unsigned B_ISO      = 11;
  localparam int unsigned B_STALL    = 12;
  localparam int unsigned B_AUTO     = 13;

  typedef struct packed {
    logic store;
    logic flip;
    logic set_ovr;
    logic set_big;
    logic set_derr;
    logic hs_vld;
    hs_e  hs;
  } rx_act_t;
endpackage

// File: rtl/ep_rx_decide.sv
module ep_rx_decide
  import usb_out_ep_pkg::*;
#(
  parameter int unsigned LEN_W = 11,
  parameter int unsigned MAXP  = 64
) (
  input  logic             pkt_valid_i,
  input  logic             pid_i,
  input  logic [LEN_W-1:0] len_i,
  input  logic             crc_err_i,
  input  logic             iso_i,
  input  logic             stall_i,
  input  logic             full_i,
  input  logic             exp_tog_i,
  output rx_act_t          act_o
);
  localparam logic [LEN_W-1:0] MAXP_L = LEN_W'(MAXP);

  always_comb begin
    act_o = '0;
    act_o.hs = HS_NONE;
    if (pkt_valid_i) begin
      if (stall_i) begin
        act_o.hs = HS_STALL;
        act_o.hs_vld = 1'b1;
      end else if (len_i > MAXP_L) begin
        act_o.set_big = 1'b1;
        act_o.hs = HS_STALL;
        act_o.hs_vld = 1'b1;
      end else if (crc_err_i) begin
        act_o.set_derr = 1'b1;
      end else if (full_i) begin
        act_o.set_ovr = 1'b1;
        act_o.hs = HS_NAK;
        act_o.hs_vld = 1'b1;
      end else if (!iso_i && (pid_i != exp_tog_i)) begin
        act_o.hs = HS_ACK;   // duplicate: ack, drop
        act_o.hs_vld = 1'b1;
      end else begin
        act_o.store = 1'b1;
        act_o.flip = !iso_i;
        act_o.hs = HS_ACK;
        act_o.hs_vld = 1'b1;
      end
      if (iso_i) begin
        act_o.hs_vld = 1'b0;
        act_o.hs = HS_NONE;
      end
    end
  end
endmodule

// File: rtl/ep_occ_ctr.sv
module ep_occ_ctr #(
  parameter int unsigned CNT_W = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       dbl_i,
  input  logic       store_i,
  input  logic       release_i,
  output logic       full_o,
  output logic [1:0] occ_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             rel_ok;

  assign rel_ok = release_i && (cnt_q != '0);
  assign full_o = dbl_i ? (cnt_q >= CNT_W'(2)) : (cnt_q >= CNT_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_q + CNT_W'(store_i) - CNT_W'(rel_ok);
  end

  always_comb begin
    unique case (cnt_q)
      CNT_W'(0): occ_o = 2'b00;
      CNT_W'(1): occ_o = dbl_i ? 2'b01 : 2'b10;
      default:   occ_o = 2'b11;
    endcase
  end
endmodule

// File: rtl/ep_flags.sv
module ep_flags #(
  parameter int unsigned NF = 3
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [NF-1:0] set_i,
  input  logic [NF-1:0] clr_i,
  output logic [NF-1:0] flag_o
);
  for (genvar g = 0; g < NF; g++) begin : g_flag
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) flag_o[g] <= 1'b0;
      else         flag_o[g] <= set_i[g] | (flag_o[g] & ~clr_i[g]); // set wins
    end
  end
endmodule

// File: rtl/usb_out_ep_ctrl.sv
module usb_out_ep_ctrl
  import usb_out_ep_pkg::*;
#(
  parameter int unsigned LEN_W = 11,
  parameter int unsigned MAXP  = 64
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             dbl_buf_i,
  input  logic             reg_wr_i,
  input  logic [15:0]      reg_wdata_i,
  output logic [15:0]      reg_rdata_o,
  input  logic             pkt_valid_i,
  input  logic             pkt_pid_i,
  input  logic [LEN_W-1:0] pkt_len_i,
  input  logic             pkt_crc_err_i,
  input  logic             rd_done_i,
  output logic             hs_valid_o,
  output logic [1:0]       hs_code_o
);
  localparam int unsigned NF = 3;

  logic [15:0]   wstb;
  logic          iso_q, stall_q, auto_q, exp_q;
  logic          full, release_set;
  logic [1:0]    occ;
  logic [NF-1:0] flags, flag_set, flag_clr;
  rx_act_t       act;
  logic          unused_wdata;

  assign wstb = reg_wr_i ? reg_wdata_i : 16'h0000;
  assign unused_wdata = ^{reg_wdata_i[15:14], reg_wdata_i[4:0]};

  ep_rx_decide #(.LEN_W(LEN_W), .MAXP(MAXP)) u_decide (
    .pkt_valid_i (pkt_valid_i),
    .pid_i       (pkt_pid_i),
    .len_i       (pkt_len_i),
    .crc_err_i   (pkt_crc_err_i),
    .iso_i       (iso_q),
    .stall_i     (stall_q | flags[1]),
    .full_i      (full),
    .exp_tog_i   (exp_q),
    .act_o       (act)
  );

  assign release_set = wstb[B_CLR_RDY] | wstb[B_FLUSH] | (auto_q & rd_done_i);

  ep_occ_ctr #(.CNT_W(2)) u_occ (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .dbl_i     (dbl_buf_i),
    .store_i   (act.store),
    .release_i (release_set),
    .full_o    (full),
    .occ_o     (occ)
  );

  assign flag_set = {act.set_derr, act.set_big, act.set_ovr};
  assign flag_clr = {wstb[B_CLR_DERR], wstb[B_CLR_BIG], wstb[B_CLR_OVR]};

  ep_flags #(.NF(NF)) u_flags (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (flag_set),
    .clr_i  (flag_clr),
    .flag_o (flags)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      iso_q      <= 1'b0;
      stall_q    <= 1'b0;
      auto_q     <= 1'b0;
      exp_q      <= 1'b0;
      hs_valid_o <= 1'b0;
      hs_code_o  <= HS_NONE;
    end else begin
      if (reg_wr_i) begin
        iso_q   <= reg_wdata_i[B_ISO];
        stall_q <= reg_wdata_i[B_STALL];
        auto_q  <= reg_wdata_i[B_AUTO];
      end
      if (wstb[B_TOG_INIT]) exp_q <= 1'b0;   // init beats flip
      else if (act.flip)    exp_q <= ~exp_q;
      hs_valid_o <= act.hs_vld;
      hs_code_o  <= act.hs;
    end
  end

  assign reg_rdata_o = {2'b00, auto_q, stall_q, iso_q, 6'b000000, flags, occ};
endmodule

// File: rtl/usb_out_ep_ctrl_chk.sv
module usb_out_ep_ctrl_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        dbl_buf_i,
  input logic        reg_wr_i,
  input logic [15:0] reg_wdata_i,
  input logic [15:0] reg_rdata_o,
  input logic        pkt_valid_i,
  input logic        hs_valid_o,
  input logic [1:0]  hs_code_o
);
  logic unused_chk;
  assign unused_chk = ^{reg_wdata_i[15:7], reg_wdata_i[5:0]};

  p_occ_legal_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dbl_buf_i |-> (reg_rdata_o[1:0] != 2'b01) && (reg_rdata_o[1:0] != 2'b11));

  p_ovr_sticky_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_rdata_o[2] && !(reg_wr_i && reg_wdata_i[6])) |=> reg_rdata_o[2]);

  p_big_stall_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pkt_valid_i && reg_rdata_o[3] && !reg_rdata_o[11]) |=> (hs_valid_o && hs_code_o == 2'b11));

  p_send_stall_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pkt_valid_i && reg_rdata_o[12] && !reg_rdata_o[11]) |=> (hs_valid_o && hs_code_o == 2'b11));

  p_iso_quiet_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pkt_valid_i && reg_rdata_o[11]) |=> !hs_valid_o);

  p_strobes_zero_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_rdata_o[10:5] == 6'd0) && (reg_rdata_o[15:14] == 2'd0));

  p_hs_after_pkt_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hs_valid_o |-> $past(pkt_valid_i));
endmodule

bind usb_out_ep_ctrl usb_out_ep_ctrl_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .dbl_buf_i   (dbl_buf_i),
  .reg_wr_i    (reg_wr_i),
  .reg_wdata_i (reg_wdata_i),
  .reg_rdata_o (reg_rdata_o),
  .pkt_valid_i (pkt_valid_i),
  .hs_valid_o  (hs_valid_o),
  .hs_code_o   (hs_code_o)
);

// File: tb/usb_out_ep_ctrl_tb.sv
`timescale 1ns/1ps
module usb_out_ep_ctrl_tb;
  localparam int unsigned LEN_W = 11;
  localparam int unsigned MAXP  = 64;

  logic             clk_i = 1'b0;
  logic             rst_ni = 1'b0;
  logic             dbl_buf_i = 1'b0;
  logic             reg_wr_i = 1'b0;
  logic [15:0]      reg_wdata_i = '0;
  logic [15:0]      reg_rdata_o;
  logic             pkt_valid_i = 1'b0;
  logic             pkt_pid_i = 1'b0;
  logic [LEN_W-1:0] pkt_len_i = '0;
  logic             pkt_crc_err_i = 1'b0;
  logic             rd_done_i = 1'b0;
  logic             hs_valid_o;
  logic [1:0]       hs_code_o;

  int n_chk = 0;
  int n_bad = 0;
  logic       last_hv;
  logic [1:0] last_hc;

  always #4 clk_i = ~clk_i;

  usb_out_ep_ctrl #(.LEN_W(LEN_W), .MAXP(MAXP)) u_dut (.*);

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic chk_eq(input string tag, input int act, input int exp);
    chk(act == exp, tag, act, exp);
  endtask

  task automatic wr(input logic [15:0] d);
    @(negedge clk_i);
    reg_wr_i = 1'b1; reg_wdata_i = d;
    @(negedge clk_i);
    reg_wr_i = 1'b0; reg_wdata_i = '0;
  endtask

  task automatic pkt(input logic pid, input int len, input logic crc);
    @(negedge clk_i);
    pkt_valid_i = 1'b1; pkt_pid_i = pid; pkt_len_i = LEN_W'(len); pkt_crc_err_i = crc;
    @(negedge clk_i);
    pkt_valid_i = 1'b0; pkt_crc_err_i = 1'b0;
    last_hv = hs_valid_o; last_hc = hs_code_o;
  endtask

  task automatic pkt_wr(input logic pid, input logic [15:0] d);
    @(negedge clk_i);
    pkt_valid_i = 1'b1; pkt_pid_i = pid; pkt_len_i = LEN_W'(8);
    reg_wr_i = 1'b1; reg_wdata_i = d;
    @(negedge clk_i);
    pkt_valid_i = 1'b0; reg_wr_i = 1'b0; reg_wdata_i = '0;
    last_hv = hs_valid_o; last_hc = hs_code_o;
  endtask

  function automatic int hsv();
    return last_hv ? int'(last_hc) : -1;
  endfunction

  task automatic t_reset();
    chk_eq("R1 reset value", int'(reg_rdata_o), 0);
    chk_eq("R10 no handshake at reset", int'(hs_valid_o), 0);
  endtask

  task automatic t_single();
    dbl_buf_i = 1'b0;
    pkt(1'b0, 8, 1'b0);
    chk_eq("R1 single one set ack", hsv(), 1);
    chk_eq("R1 single occupancy 10", int'(reg_rdata_o[1:0]), 2);
    pkt(1'b1, 8, 1'b0);
    chk_eq("R2 full gives NAK", hsv(), 2);
    chk_eq("R2 overrun set", int'(reg_rdata_o[2]), 1);
    chk_eq("R2 occupancy unchanged", int'(reg_rdata_o[1:0]), 2);
    wr(16'h0020);
    chk_eq("R5 buffer ready releases", int'(reg_rdata_o[1:0]), 0);
    chk_eq("R2 overrun sticky", int'(reg_rdata_o[2]), 1);
    wr(16'h0040);
    chk_eq("R2 overrun cleared", int'(reg_rdata_o[2]), 0);
  endtask

  task automatic t_double();
    dbl_buf_i = 1'b1;
    pkt(1'b1, 8, 1'b0);
    chk_eq("R1 double one set 01", int'(reg_rdata_o[1:0]), 1);
    pkt(1'b0, 8, 1'b0);
    chk_eq("R1 double two sets 11", int'(reg_rdata_o[1:0]), 3);
    pkt(1'b1, 8, 1'b0);
    chk_eq("R2 double full NAK", hsv(), 2);
    chk_eq("R2 double overrun", int'(reg_rdata_o[2]), 1);
    wr(16'h0400);
    chk_eq("R5 flush one", int'(reg_rdata_o[1:0]), 1);
    wr(16'h0400);
    chk_eq("R5 flush two", int'(reg_rdata_o[1:0]), 0);
    wr(16'h0400);
    chk_eq("R5 flush empty no effect", int'(reg_rdata_o[1:0]), 0);
    wr(16'h0040);
  endtask

  task automatic t_toggle();
    pkt(1'b0, 8, 1'b0);
    chk_eq("R7 wrong pid acked", hsv(), 1);
    chk_eq("R7 wrong pid not stored", int'(reg_rdata_o[1:0]), 0);
    wr(16'h0200);
    pkt(1'b0, 8, 1'b0);
    chk_eq("R7 after init DATA0 stored", int'(reg_rdata_o[1:0]), 1);
    wr(16'h0400);
  endtask

  task automatic t_big();
    pkt(1'b1, MAXP + 1, 1'b0);
    chk_eq("R3 oversize STALL", hsv(), 3);
    chk_eq("R3 oversize flag", int'(reg_rdata_o[3]), 1);
    chk_eq("R3 oversize not stored", int'(reg_rdata_o[1:0]), 0);
    pkt(1'b1, 4, 1'b0);
    chk_eq("R3 stall while flag", hsv(), 3);
    chk_eq("R3 nothing stored while flag", int'(reg_rdata_o[1:0]), 0);
    wr(16'h0080);
    chk_eq("R3 flag cleared", int'(reg_rdata_o[3]), 0);
    pkt(1'b1, MAXP, 1'b0);
    chk_eq("R3 MAXP accepted", hsv(), 1);
    chk_eq("R3 MAXP stored", int'(reg_rdata_o[1:0]), 1);
    wr(16'h0400);
  endtask

  task automatic t_crc();
    pkt(1'b0, 8, 1'b1);
    chk_eq("R4 crc no handshake", hsv(), -1);
    chk_eq("R4 data error flag", int'(reg_rdata_o[4]), 1);
    chk_eq("R4 not stored", int'(reg_rdata_o[1:0]), 0);
    wr(16'h0100);
    chk_eq("R4 flag cleared", int'(reg_rdata_o[4]), 0);
  endtask

  task automatic t_stall();
    wr(16'h1000);
    chk_eq("R10 stall bit reads back", int'(reg_rdata_o[12]), 1);
    pkt(1'b0, 8, 1'b0);
    chk_eq("R8 send stall", hsv(), 3);
    chk_eq("R8 nothing stored", int'(reg_rdata_o[1:0]), 0);
    wr(16'h0000);
    pkt(1'b0, 8, 1'b0);
    chk_eq("R8 resumed ack", hsv(), 1);
    chk_eq("R8 resumed stored", int'(reg_rdata_o[1:0]), 1);
    wr(16'h0400);
  endtask

  task automatic t_auto();
    pkt(1'b1, 8, 1'b0);
    @(negedge clk_i); rd_done_i = 1'b1;
    @(negedge clk_i); rd_done_i = 1'b0;
    chk_eq("R6 rd_done ignored without auto", int'(reg_rdata_o[1:0]), 1);
    wr(16'h2000);
    @(negedge clk_i); rd_done_i = 1'b1;
    @(negedge clk_i); rd_done_i = 1'b0;
    chk_eq("R6 auto release", int'(reg_rdata_o[1:0]), 0);
    wr(16'h0000);
  endtask

  task automatic t_iso();
    wr(16'h0800);
    pkt(1'b1, 8, 1'b0);
    chk_eq("R9 iso no handshake", hsv(), -1);
    chk_eq("R9 iso stored despite pid", int'(reg_rdata_o[1:0]), 1);
    wr(16'h0C00);
    wr(16'h0000);
  endtask

  task automatic t_race();
    pkt(1'b0, 8, 1'b0);
    pkt(1'b1, 8, 1'b0);
    pkt(1'b0, 8, 1'b0);
    chk_eq("R2 overrun before race", int'(reg_rdata_o[2]), 1);
    pkt_wr(1'b0, 16'h0040);
    chk_eq("R11 set wins over clear", int'(reg_rdata_o[2]), 1);
    wr(16'h07E0);
    chk_eq("R10 strobes read zero", int'(reg_rdata_o[15:2]), 0);
    chk_eq("R5 one release per write", int'(reg_rdata_o[1:0]), 1);
    wr(16'h0400);
    pkt_wr(1'b0, 16'h0200);
    pkt(1'b0, 8, 1'b0);
    chk_eq("R7 init wins over flip", int'(reg_rdata_o[1:0]), 3);
  endtask

  initial begin
    #2_000_000;
    n_bad++;
    n_chk++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    t_reset();
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_single();
    t_double();
    t_toggle();
    t_big();
    t_crc();
    t_stall();
    t_auto();
    t_iso();
    t_race();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule